// File: doc/BRIEF.md
# NAND device probe and geometry unit

This block identifies the NAND devices attached to a controller once, when it is started after reset. It walks every chip-select in turn. For each one it sends a device reset, waits for the device to report ready, issues a read-ID operation and collects the eight ID bytes that follow. The first chip-select decides whether a usable device is present at all. The geometry comes from the device code and two further ID bytes of that first chip-select. The die count is the number of chip-selects that return the same device code.

The pin-level NAND bus is not driven here. Instead, the block talks to a bus engine through a byte-wide request channel and a read-return channel. Each request is a command byte, an address byte or a data-read request, and it is accepted when valid and ready are both high. The read-return channel carries one byte per accepted read request. The device ready/busy line of the selected chip-select comes in directly.

When the probe ends, a one-cycle done pulse is raised. The status code, the geometry fields, the die count and the total block count are then held until the next start.

Top module: `nand_probe`

## Requirements
- R1: After reset, busy_o, done_o and bus_valid_o are low, and status_o, every geometry output, die_count_o and total_blk_o are zero.
- R2: For each chip-select, starting at 0 and counting up, the request order is: command 0xFF, command 0x90, address 0x00, then eight read requests. The kind encoding is 0 = command, 1 = address, 2 = data read. The first read is accepted at least DLY_CYC clock cycles after the address byte.
- R3: The 0x90 command for a chip-select is issued only after dev_ready_i has been seen high following that chip-select's 0xFF command.
- R4: If chip-select 0 returns ID byte 0 equal to 0xFF or 0x00, or ID byte 1 equal to 0xFF, the probe ends with status 1 (no device). No other chip-select is accessed, and die_count_o, total_blk_o and the geometry read zero.
- R5: If chip-select 0 passes R4 but its ID byte 1 is none of 0xF1, 0xDA, 0xD1, 0x95 or 0xDC, the probe ends with status 2 (unsupported) and no other chip-select is accessed.
- R6: A successful probe ends with status 0. Any device code other than 0xDA and 0xDC gives 4 sectors per page, 64 pages per block, 1 plane per die and 1024 blocks per plane.
- R7: Device code 0xDA gives 2 planes per die and otherwise the defaults.
- R8: Device code 0xDC with ID byte 0 = 0x2C and ID byte 3 = 0xA6 gives 2 planes per die and 8 sectors per page. Any other 0xDC device gives 2 planes per die and 2048 blocks per plane.
- R9: die_count_o is the number of chip-selects whose ID byte 1 equals that of chip-select 0. total_blk_o = die_count_o × planes per die × blocks per plane.
- R10: If dev_ready_i stays low for TIMEOUT_CYC cycles after a reset command, the probe ends with status 3 (timeout). The geometry and counts then read zero.
- R11: done_o is high for exactly one cycle, with busy_o low. After that, all results stay unchanged until start_i is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a probe when idle |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | One-cycle end-of-probe pulse |
| bus_valid_o | output | 1 | Request to the bus engine is valid |
| bus_ready_i | input | 1 | Bus engine accepts the request |
| bus_kind_o | output | 2 | 0 command, 1 address, 2 data read |
| bus_byte_o | output | 8 | Command or address byte |
| bus_cs_o | output | CS_W | Chip-select being probed |
| rd_valid_i | input | 1 | Returned read byte is valid |
| rd_byte_i | input | 8 | Returned read byte |
| dev_ready_i | input | 1 | Ready/busy line of the selected device, high = ready |
| status_o | output | 2 | 0 ok, 1 no device, 2 unsupported, 3 timeout |
| sec_per_page_o | output | 4 | Sectors per page |
| page_per_blk_o | output | 8 | Pages per block |
| plane_per_die_o | output | 2 | Planes per die |
| blk_per_plane_o | output | 12 | Blocks per plane |
| die_count_o | output | DIE_W | Chip-selects carrying the same device |
| total_blk_o | output | TOT_W | Total block count |

## Verification
The hardest case to reach is a ready timeout on a later chip-select after the earlier ones have been read in full. The result must then be a timeout with zeroed counts, and the request trace must end with exactly one reset command on the stuck chip-select. The bench models every chip-select with its own ID bytes, busy length and a stuck-busy flag. Directed cases set that flag on chip-select 2 and on chip-select 0. Random runs vary device codes, busy lengths and bus stalls, and force the 0x2C/0xA6 pair on half of the 0xDC devices so that both branches of that decode are hit.

// File: rtl/nprb_pkg.sv
package nprb_pkg;

  localparam int SPP_W      = 4;
  localparam int PPB_W      = 8;
  localparam int PLN_W      = 2;
  localparam int BPP_W      = 12;
  localparam int MAX_PLANES = 2;
  localparam int MAX_BPP    = 2048;
  localparam int ID_LEN     = 8;

  localparam logic [7:0] OP_RESET   = 8'hFF;
  localparam logic [7:0] OP_READ_ID = 8'h90;
  localparam logic [7:0] ID_ADDR    = 8'h00;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_READ = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    P_OK      = 2'd0,
    P_NODEV   = 2'd1,
    P_UNSUP   = 2'd2,
    P_TIMEOUT = 2'd3
  } pstat_e;

  typedef struct packed {
    logic [SPP_W-1:0] spp;
    logic [PPB_W-1:0] ppb;
    logic [PLN_W-1:0] planes;
    logic [BPP_W-1:0] bpp;
  } geom_t;

  // no device answers: floating or shorted ID bus
  function automatic logic id_absent(input logic [7:0] b0, input logic [7:0] b1);
    return (b0 == 8'hFF) || (b0 == 8'h00) || (b1 == 8'hFF);
  endfunction

  function automatic logic code_known(input logic [7:0] b1);
    logic k;
    case (b1)
      8'hF1, 8'hDA, 8'hD1, 8'h95, 8'hDC: k = 1'b1;
      default:                           k = 1'b0;
    endcase
    return k;
  endfunction

  function automatic geom_t geom_from_id(input logic [7:0] b0, input logic [7:0] b1,
                                         input logic [7:0] b3);
    geom_t g;
    g.spp    = SPP_W'(4);
    g.ppb    = PPB_W'(64);
    g.planes = PLN_W'(1);
    g.bpp    = BPP_W'(1024);
    if (b1 == 8'hDA) begin
      g.planes = PLN_W'(2);
    end else if (b1 == 8'hDC) begin
      g.planes = PLN_W'(2);
      if (b0 == 8'h2C && b3 == 8'hA6) g.spp = SPP_W'(8);
      else                            g.bpp = BPP_W'(2048);
    end
    return g;
  endfunction

  function automatic logic [31:0] blocks_total(input logic [31:0] dies,
                                               input logic [31:0] planes,
                                               input logic [31:0] bpp);
    return dies * planes * bpp;
  endfunction

endpackage

// File: rtl/nprb_tick_timer.sv
module nprb_tick_timer #(
  parameter int DLY_CYC     = 40,
  parameter int TIMEOUT_CYC = 4096,
  localparam int LIMIT = (DLY_CYC > TIMEOUT_CYC) ? DLY_CYC : TIMEOUT_CYC,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic dly_hit_o,
  output logic tmo_hit_o
);

  logic [CNT_W-1:0] cnt_q;

  // counts cycles spent in a waiting state, restarts whenever the state is left
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign dly_hit_o = run_i && (cnt_q == CNT_W'(DLY_CYC - 1));
  assign tmo_hit_o = run_i && (cnt_q == CNT_W'(TIMEOUT_CYC - 1));

  AST_TMR_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < CNT_W'(LIMIT))); // R10

endmodule

// File: rtl/nprb_id_capture.sv
module nprb_id_capture #(
  parameter int LEN = nprb_pkg::ID_LEN,
  localparam int IDX_W = $clog2(LEN)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       take_i,
  input  logic [7:0] byte_i,
  output logic [7:0] b0_o,
  output logic [7:0] b1_o,
  output logic [7:0] b3_o,
  output logic       last_o
);

  logic [IDX_W-1:0] idx_q;

  assign last_o = take_i && (idx_q == IDX_W'(LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      b0_o  <= '0;
      b1_o  <= '0;
      b3_o  <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
    end else if (take_i) begin
      idx_q <= last_o ? '0 : idx_q + 1'b1;
      if (idx_q == IDX_W'(0)) b0_o <= byte_i;
      if (idx_q == IDX_W'(1)) b1_o <= byte_i;
      if (idx_q == IDX_W'(3)) b3_o <= byte_i;
    end
  end

  AST_NO_TAKE_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_i && take_i)); // R2

endmodule

// File: rtl/nprb_geom_decode.sv
module nprb_geom_decode (
  input  logic [7:0]      b0_i,
  input  logic [7:0]      b1_i,
  input  logic [7:0]      b3_i,
  output nprb_pkg::geom_t geom_o
);
  import nprb_pkg::*;

  assign geom_o = geom_from_id(b0_i, b1_i, b3_i);

endmodule

// File: rtl/nand_probe.sv
module nand_probe #(
  parameter int NUM_CS      = 4,
  parameter int DLY_CYC     = 40,
  parameter int TIMEOUT_CYC = 4096,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int DIE_W = $clog2(NUM_CS + 1),
  localparam int TOT_W = $clog2(NUM_CS * nprb_pkg::MAX_PLANES * nprb_pkg::MAX_BPP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             bus_valid_o,
  input  logic             bus_ready_i,
  output logic [1:0]       bus_kind_o,
  output logic [7:0]       bus_byte_o,
  output logic [CS_W-1:0]  bus_cs_o,
  input  logic             rd_valid_i,
  input  logic [7:0]       rd_byte_i,
  input  logic             dev_ready_i,
  output logic [1:0]       status_o,
  output logic [3:0]       sec_per_page_o,
  output logic [7:0]       page_per_blk_o,
  output logic [1:0]       plane_per_die_o,
  output logic [11:0]      blk_per_plane_o,
  output logic [DIE_W-1:0] die_count_o,
  output logic [TOT_W-1:0] total_blk_o
);
  import nprb_pkg::*;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_CMD, S_RST_WAIT, S_ID_CMD, S_ID_ADDR,
    S_ID_DLY, S_RD_REQ, S_RD_RESP, S_EVAL, S_FIN
  } st_e;

  st_e              st_q, st_d;
  pstat_e           pend_q, pend_d, status_q;
  logic [CS_W-1:0]  cs_q;
  logic [DIE_W-1:0] match_q, dies_q;
  logic [7:0]       id0_b0_q, id0_b1_q, id0_b3_q;
  geom_t            geom_q, geom_w;
  logic [TOT_W-1:0] total_q;
  logic             done_q;

  // named internal events
  logic             accept_w, take_w, cap_last_w, dly_hit_w, tmo_hit_w, tmr_run_w;
  logic             id_cmd_w, cs0_w, last_cs_w;
  logic [7:0]       cap_b0_w, cap_b1_w, cap_b3_w;

  // ---------------- request channel ----------------
  always_comb begin
    bus_valid_o = 1'b0;
    bus_kind_o  = K_CMD;
    bus_byte_o  = 8'h00;
    case (st_q)
      S_RST_CMD: begin bus_valid_o = 1'b1; bus_byte_o = OP_RESET;   end
      S_ID_CMD:  begin bus_valid_o = 1'b1; bus_byte_o = OP_READ_ID; end
      S_ID_ADDR: begin bus_valid_o = 1'b1; bus_kind_o = K_ADDR; bus_byte_o = ID_ADDR; end
      S_RD_REQ:  begin bus_valid_o = 1'b1; bus_kind_o = K_READ; end
      default:   ;
    endcase
  end

  assign bus_cs_o  = cs_q;
  assign accept_w  = bus_valid_o && bus_ready_i;
  assign id_cmd_w  = bus_valid_o && (bus_kind_o == K_CMD) && (bus_byte_o == OP_READ_ID);
  assign take_w    = (st_q == S_RD_RESP) && rd_valid_i;
  assign tmr_run_w = (st_q == S_RST_WAIT) || (st_q == S_ID_DLY);
  assign cs0_w     = (cs_q == '0);
  assign last_cs_w = (cs_q == CS_W'(NUM_CS - 1));

  // ---------------- sub-blocks ----------------
  nprb_tick_timer #(
    .DLY_CYC     (DLY_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (tmr_run_w),
    .dly_hit_o (dly_hit_w),
    .tmo_hit_o (tmo_hit_w)
  );

  nprb_id_capture #(
    .LEN (ID_LEN)
  ) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (st_q == S_ID_CMD),
    .take_i (take_w),
    .byte_i (rd_byte_i),
    .b0_o   (cap_b0_w),
    .b1_o   (cap_b1_w),
    .b3_o   (cap_b3_w),
    .last_o (cap_last_w)
  );

  nprb_geom_decode u_geom (
    .b0_i   (id0_b0_q),
    .b1_i   (id0_b1_q),
    .b3_i   (id0_b3_q),
    .geom_o (geom_w)
  );

  // ---------------- sequencer ----------------
  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    case (st_q)
      S_IDLE:     if (start_i) st_d = S_RST_CMD;
      S_RST_CMD:  if (accept_w) st_d = S_RST_WAIT;
      S_RST_WAIT: begin
        if (dev_ready_i) begin
          st_d = S_ID_CMD;
        end else if (tmo_hit_w) begin
          st_d   = S_FIN;
          pend_d = P_TIMEOUT;
        end
      end
      S_ID_CMD:   if (accept_w) st_d = S_ID_ADDR;
      S_ID_ADDR:  if (accept_w) st_d = S_ID_DLY;
      S_ID_DLY:   if (dly_hit_w) st_d = S_RD_REQ;
      S_RD_REQ:   if (accept_w) st_d = S_RD_RESP;
      S_RD_RESP:  if (take_w) st_d = cap_last_w ? S_EVAL : S_RD_REQ;
      S_EVAL: begin
        if (cs0_w && id_absent(cap_b0_w, cap_b1_w)) begin
          st_d   = S_FIN;
          pend_d = P_NODEV;
        end else if (cs0_w && !code_known(cap_b1_w)) begin
          st_d   = S_FIN;
          pend_d = P_UNSUP;
        end else if (last_cs_w) begin
          st_d   = S_FIN;
          pend_d = P_OK;
        end else begin
          st_d = S_RST_CMD;
        end
      end
      S_FIN:      st_d = S_IDLE;
      default:    st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      pend_q   <= P_OK;
      status_q <= P_OK;
      cs_q     <= '0;
      match_q  <= '0;
      dies_q   <= '0;
      id0_b0_q <= '0;
      id0_b1_q <= '0;
      id0_b3_q <= '0;
      geom_q   <= '0;
      total_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      done_q <= 1'b0;
      if (st_q == S_IDLE && start_i) begin
        cs_q    <= '0;
        match_q <= '0;
      end
      if (st_q == S_EVAL) begin
        if (cs0_w) begin
          id0_b0_q <= cap_b0_w;
          id0_b1_q <= cap_b1_w;
          id0_b3_q <= cap_b3_w;
        end
        if (cs0_w || (cap_b1_w == id0_b1_q)) match_q <= match_q + 1'b1;
        if (st_d == S_RST_CMD) cs_q <= cs_q + 1'b1;
      end
      if (st_q == S_FIN) begin
        done_q   <= 1'b1;
        status_q <= pend_q;
        if (pend_q == P_OK) begin
          geom_q  <= geom_w;
          dies_q  <= match_q;
          total_q <= TOT_W'(blocks_total(32'(match_q), 32'(geom_w.planes), 32'(geom_w.bpp)));
        end else begin
          geom_q  <= '0;
          dies_q  <= '0;
          total_q <= '0;
        end
      end
    end
  end

  assign busy_o          = (st_q != S_IDLE);
  assign done_o          = done_q;
  assign status_o        = status_q;
  assign sec_per_page_o  = geom_q.spp;
  assign page_per_blk_o  = geom_q.ppb;
  assign plane_per_die_o = geom_q.planes;
  assign blk_per_plane_o = geom_q.bpp;
  assign die_count_o     = dies_q;
  assign total_blk_o     = total_q;

  // ---------------- assertions ----------------
  AST_ID_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_cmd_w) |-> $past(dev_ready_i)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R11

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(status_o) && $stable(total_blk_o))); // R11

  AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o != P_OK) |-> (die_count_o == '0 && total_blk_o == '0)); // R4

  AST_GEOM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == P_OK) |->
      ((plane_per_die_o == 2'd1 || plane_per_die_o == 2'd2) &&
       (sec_per_page_o == 4'd4 || sec_per_page_o == 4'd8))); // R8

  AST_DIES_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == P_OK) |-> (die_count_o != '0)); // R9

endmodule

// File: tb/nand_probe_tb.sv
`timescale 1ns/1ps
module nand_probe_tb;
  import nprb_pkg::*;

  localparam int NUM_CS = 4;
  localparam int DLY    = 40;
  localparam int TMO    = 600;
  localparam int CS_W   = 2;
  localparam int DIE_W  = $clog2(NUM_CS + 1);
  localparam int TOT_W  = $clog2(NUM_CS * MAX_PLANES * MAX_BPP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, done_o, bus_valid_o;
  logic bus_ready_i = 1'b1;
  logic [1:0] bus_kind_o;
  logic [7:0] bus_byte_o;
  logic [CS_W-1:0] bus_cs_o;
  logic rd_valid_i = 1'b0;
  logic [7:0] rd_byte_i = 8'h00;
  logic dev_ready_i;
  logic [1:0] status_o;
  logic [3:0] sec_per_page_o;
  logic [7:0] page_per_blk_o;
  logic [1:0] plane_per_die_o;
  logic [11:0] blk_per_plane_o;
  logic [DIE_W-1:0] die_count_o;
  logic [TOT_W-1:0] total_blk_o;

  always #2.5 clk = ~clk;

  nand_probe #(.NUM_CS(NUM_CS), .DLY_CYC(DLY), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .bus_valid_o(bus_valid_o), .bus_ready_i(bus_ready_i), .bus_kind_o(bus_kind_o),
    .bus_byte_o(bus_byte_o), .bus_cs_o(bus_cs_o), .rd_valid_i(rd_valid_i),
    .rd_byte_i(rd_byte_i), .dev_ready_i(dev_ready_i), .status_o(status_o),
    .sec_per_page_o(sec_per_page_o), .page_per_blk_o(page_per_blk_o),
    .plane_per_die_o(plane_per_die_o), .blk_per_plane_o(blk_per_plane_o),
    .die_count_o(die_count_o), .total_blk_o(total_blk_o)
  );

  // ---------------- device and bus-engine model ----------------
  logic [7:0] id_mem [NUM_CS][8];
  int  busy_len [NUM_CS];
  bit  stuck [NUM_CS];
  int  stall_pct = 0;
  int  rb_cnt = 0;
  bit  rb_hold = 1'b0;
  int  rd_ptr = 0;
  int  cyc = 0;
  int  ev_kind [64];
  int  ev_byte [64];
  int  ev_cs [64];
  int  ev_cyc [64];
  bit  ev_rdy [64];
  int  ev_cnt = 0;
  int  n_chk = 0;
  int  n_err = 0;

  assign dev_ready_i = (rb_cnt == 0) && !rb_hold;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    bus_ready_i <= ($urandom_range(99) >= stall_pct);
    rd_valid_i <= 1'b0;
    if (rb_cnt > 0) rb_cnt <= rb_cnt - 1;
    if (bus_valid_o && bus_ready_i) begin
      if (ev_cnt < 64) begin
        ev_kind[ev_cnt] = int'(bus_kind_o);
        ev_byte[ev_cnt] = int'(bus_byte_o);
        ev_cs[ev_cnt]   = int'(bus_cs_o);
        ev_cyc[ev_cnt]  = cyc;
        ev_rdy[ev_cnt]  = dev_ready_i;
      end
      ev_cnt = ev_cnt + 1;
      if (bus_kind_o == 2'd0 && bus_byte_o == 8'hFF) begin
        rb_cnt  <= busy_len[bus_cs_o];
        rb_hold <= stuck[bus_cs_o];
      end else if (bus_kind_o == 2'd0 && bus_byte_o == 8'h90) begin
        rd_ptr <= 0;
      end else if (bus_kind_o == 2'd2) begin
        rd_valid_i <= 1'b1;
        rd_byte_i  <= id_mem[bus_cs_o][rd_ptr % 8];
        rd_ptr     <= rd_ptr + 1;
      end
    end
  end

  // ---------------- bench helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_dev(input int c, input int b0, input int b1, input int b3,
                         input int bl, input bit stk);
    for (int k = 0; k < 8; k++) id_mem[c][k] = 8'($urandom);
    id_mem[c][0] = 8'(b0);
    id_mem[c][1] = 8'(b1);
    id_mem[c][3] = 8'(b3);
    busy_len[c] = bl;
    stuck[c] = stk;
  endtask

  task automatic set_empty(input int c);
    for (int k = 0; k < 8; k++) id_mem[c][k] = 8'hFF;
    busy_len[c] = 0;
    stuck[c] = 1'b0;
  endtask

  function automatic bit supported_code(input int b1);
    return (b1 == 'hF1) || (b1 == 'hDA) || (b1 == 'hD1) || (b1 == 'h95) || (b1 == 'hDC);
  endfunction

  // geometry restated as a table of cases
  task automatic exp_geom(input int b0, input int b1, input int b3,
                          output int spp, output int ppb, output int pl, output int bpp);
    ppb = 64;
    case (b1)
      'hDA: begin spp = 4; pl = 2; bpp = 1024; end
      'hDC: begin
        if (b0 == 'h2C && b3 == 'hA6) begin spp = 8; pl = 2; bpp = 1024; end
        else                          begin spp = 4; pl = 2; bpp = 2048; end
      end
      default: begin spp = 4; pl = 1; bpp = 1024; end
    endcase
  endtask

  task automatic run_case(input string tag);
    int e_st, n_full, e_spp, e_ppb, e_pl, e_bpp, e_dies, t0, t1, exp_ev;
    bit to_last, ok_ord, ok_rdy, ok_dly;
    e_st = 0; n_full = NUM_CS; to_last = 1'b0;
    if (stuck[0]) begin
      e_st = 3; n_full = 0; to_last = 1'b1;
    end else if (id_mem[0][0] == 8'hFF || id_mem[0][0] == 8'h00 || id_mem[0][1] == 8'hFF) begin
      e_st = 1; n_full = 1;
    end else if (!supported_code(int'(id_mem[0][1]))) begin
      e_st = 2; n_full = 1;
    end else begin
      for (int c = 1; c < NUM_CS; c++) begin
        if (stuck[c] && !to_last) begin e_st = 3; n_full = c; to_last = 1'b1; end
      end
    end
    exp_geom(int'(id_mem[0][0]), int'(id_mem[0][1]), int'(id_mem[0][3]),
             e_spp, e_ppb, e_pl, e_bpp);
    e_dies = 0;
    for (int c = 0; c < NUM_CS; c++) if (id_mem[c][1] == id_mem[0][1]) e_dies++;

    @(negedge clk);
    ev_cnt = 0;
    t0 = cyc;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 20000 && !done_o; i++) @(negedge clk);
    t1 = cyc;
    chk(done_o == 1'b1, "R11", {tag, " done seen"}, done_o, 1);
    chk(int'(status_o) == e_st, tag, "status", status_o, e_st);
    if (e_st == 0) begin
      chk(int'(sec_per_page_o) == e_spp, tag, "sectors/page", sec_per_page_o, e_spp);
      chk(int'(page_per_blk_o) == e_ppb, "R6", "pages/block", page_per_blk_o, e_ppb);
      chk(int'(plane_per_die_o) == e_pl, tag, "planes/die", plane_per_die_o, e_pl);
      chk(int'(blk_per_plane_o) == e_bpp, tag, "blocks/plane", blk_per_plane_o, e_bpp);
      chk(int'(die_count_o) == e_dies, "R9", "die count", die_count_o, e_dies);
      chk(int'(total_blk_o) == e_dies * e_pl * e_bpp, "R9", "total blocks",
          total_blk_o, e_dies * e_pl * e_bpp);
    end else begin
      chk(die_count_o == '0 && total_blk_o == '0 && plane_per_die_o == '0, "R4",
          "counts zero on failure", total_blk_o, 0);
    end
    if (e_st == 3) chk(t1 - t0 >= TMO, "R10", "timeout length", t1 - t0, TMO);

    exp_ev = n_full * 11 + (to_last ? 1 : 0);
    chk(ev_cnt == exp_ev, "R2", {tag, " request count"}, ev_cnt, exp_ev);
    ok_ord = 1'b1; ok_rdy = 1'b1; ok_dly = 1'b1;
    for (int g = 0; g < n_full; g++) begin
      int b;
      b = g * 11;
      if (ev_kind[b] != 0 || ev_byte[b] != 'hFF || ev_cs[b] != g) ok_ord = 1'b0;
      if (ev_kind[b+1] != 0 || ev_byte[b+1] != 'h90 || ev_cs[b+1] != g) ok_ord = 1'b0;
      if (ev_kind[b+2] != 1 || ev_byte[b+2] != 'h00 || ev_cs[b+2] != g) ok_ord = 1'b0;
      for (int r = 3; r < 11; r++) if (ev_kind[b+r] != 2 || ev_cs[b+r] != g) ok_ord = 1'b0;
      if (!ev_rdy[b+1]) ok_rdy = 1'b0;
      if (ev_cyc[b+3] - ev_cyc[b+2] < DLY) ok_dly = 1'b0;
    end
    if (to_last && ev_cnt == exp_ev)
      if (ev_kind[exp_ev-1] != 0 || ev_byte[exp_ev-1] != 'hFF || ev_cs[exp_ev-1] != n_full)
        ok_ord = 1'b0;
    chk(ok_ord, "R2", {tag, " request order"}, ok_ord, 1);
    chk(ok_rdy, "R3", {tag, " ID command after ready"}, ok_rdy, 1);
    chk(ok_dly, "R2", {tag, " delay before reads"}, ok_dly, 1);

    @(negedge clk);
    chk(!done_o && !busy_o, "R11", "done is one cycle", done_o, 0);
    repeat (5) @(negedge clk);
    chk(int'(status_o) == e_st, "R11", "status held", status_o, e_st);
  endtask

  task automatic all_present(input int code, input int b0, input int b3, input int bl);
    set_dev(0, b0, code, b3, bl, 1'b0);
    for (int c = 1; c < NUM_CS; c++) set_dev(c, b0, code, b3, bl, 1'b0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  // ---------------- stimulus ----------------
  int codes [5] = '{'hF1, 'hDA, 'hD1, 'h95, 'hDC};

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < NUM_CS; c++) set_empty(c);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !bus_valid_o, "R1", "idle flags", busy_o, 0);
    chk(status_o == '0 && sec_per_page_o == '0 && blk_per_plane_o == '0 &&
        die_count_o == '0 && total_blk_o == '0, "R1", "zero results", total_blk_o, 0);

    // directed: geometry variants
    stall_pct = 0;
    all_present('hF1, 'h98, 'h15, 5);  run_case("R6");
    all_present('hDA, 'hEC, 'h15, 12); run_case("R7");
    all_present('hDC, 'h2C, 'hA6, 3);  run_case("R8");
    all_present('hDC, 'h2C, 'h90, 3);  run_case("R8");
    all_present('hDC, 'hAD, 'hA6, 0);  run_case("R8");

    // directed: die counting with mixed chip-selects
    set_dev(0, 'h01, 'hD1, 0, 7, 1'b0);
    set_empty(1);
    set_dev(2, 'h01, 'hD1, 0, 2, 1'b0);
    set_dev(3, 'h01, 'h95, 0, 2, 1'b0);
    run_case("R9");

    // directed: absence and unsupported codes
    all_present('hF1, 'hFF, 0, 1); run_case("R4");
    all_present('hF1, 'h00, 0, 1); run_case("R4");
    set_dev(0, 'h98, 'hFF, 0, 1, 1'b0); run_case("R4");
    all_present('h12, 'h98, 0, 1); run_case("R5");

    // directed: ready timeouts on first and on a later chip-select
    all_present('hF1, 'h98, 0, 4);
    stuck[2] = 1'b1;
    run_case("R10");
    all_present('hF1, 'h98, 0, 4);
    stuck[0] = 1'b1;
    run_case("R10");

    // random
    for (int it = 0; it < 25; it++) begin
      int code, b0, b3;
      code = codes[$urandom_range(4)];
      b0 = $urandom_range(254, 1);
      b3 = $urandom_range(255);
      if (code == 'hDC && $urandom_range(1) == 1) begin b0 = 'h2C; b3 = 'hA6; end
      stall_pct = $urandom_range(50);
      set_dev(0, b0, code, b3, $urandom_range(40), 1'b0);
      for (int c = 1; c < NUM_CS; c++) begin
        case ($urandom_range(2))
          0: set_dev(c, $urandom_range(254, 1), code, $urandom_range(255), $urandom_range(40), 1'b0);
          1: set_dev(c, $urandom_range(254, 1), code ^ 'h01, 0, $urandom_range(40), 1'b0);
          default: set_empty(c);
        endcase
      end
      run_case("R9");
    end
    stall_pct = 0;

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule